// File: doc/BRIEF.md
# Cascadable Codec Serial-Port Frame Controller

This block is the timing and framing engine of the serial port on a voice-band codec. It runs from the master clock. When it is master, it makes the shift clock and an active-low frame sync. When it is slave, it takes both from outside and brings them into the master-clock domain. While frame sync is low it moves one 16-bit word each way, MSB first. A delayed copy of the frame sync leaves the block so that a second device can be chained behind it and take the next 16-bit slot.

The frame length in shift-clock periods depends on the cascade count. It is 256 for one to four chained devices and 512 for five to eight. A hardware request adds a secondary (control) frame midway through the next frame period. A flag output shows whether the current frame is primary or secondary, or else a fixed bit from a small control register. An active-low power-down stops the port and clears its counters but keeps the register. Reset restores every default.

Top module: `codec_sport_frame`

## Requirements
- R1: In master mode the shift clock toggles on every master clock. Frame sync falls once every 2*L master clocks, with L shift-clock rising edges per frame. L is 256 when the cascade count is 1 to 4 and 512 when it is 5 to 8.
- R2: In master mode frame sync falls on the same master clock as a shift-clock rising edge. It stays low for exactly 16 shift-clock periods (32 master clocks).
- R3: tx_word is captured when frame sync falls and appears on dout MSB first, one bit per rising edge. The first bit appears with the frame-sync fall. din is sampled on each falling edge. After the 16th bit, rx_word holds the received word (MSB first) and rx_valid pulses for one clock while frame sync is still low.
- R4: The delayed frame-sync output falls 16 shift-clock periods after the local frame starts and stays low for 16 periods. A slave fed by it falls its own delayed output 34 master clocks after the master's delayed output falls, because of two clocks of input synchronisation.
- R5: A sec_req pulse during a primary frame places one secondary frame L master clocks after that primary frame starts. The next primary frame follows L clocks later, and the request is then cleared, so the next period has no secondary frame.
- R6: cfg_q bit 4 selects the flag source. When it is 0, flag_o is low during primary frames and high during secondary frames. When it is 1, flag_o equals cfg_q bit 3.
- R7: While pwrdn_n is low, sclk_o is low, fs_o and fsd_o are high and dout is low. After pwrdn_n rises, a frame starts on the first master clock.
- R8: cfg_q changes only on a clock with cfg_we high, and it keeps its value across power-down.
- R9: Reset sets cfg_q to 0, fs_o and fsd_o high, sclk_o low and flag_o low.
- R10: In slave mode sclk_o stays low and fs_o stays high. Framing follows sclk_i and fs_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| pwrdn_n | input | 1 | Active-low power-down |
| master_sel | input | 1 | 1 = master, 0 = slave |
| casc_cnt | input | CASC_W | Number of cascaded devices (1..8) |
| sec_req | input | 1 | Request for a secondary frame |
| sclk_i | input | 1 | Shift clock in slave mode |
| fs_i | input | 1 | Active-low frame sync in slave mode |
| din | input | 1 | Serial data in |
| tx_word | input | SLOT_BITS | Word to send in the next frame |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | CFG_W | Control register write data |
| sclk_o | output | 1 | Shift clock in master mode |
| fs_o | output | 1 | Active-low frame sync in master mode |
| fsd_o | output | 1 | Delayed frame sync for the next device |
| dout | output | 1 | Serial data out |
| rx_word | output | SLOT_BITS | Last received word |
| rx_valid | output | 1 | One-clock pulse when rx_word updates |
| flag_o | output | 1 | Frame-type or fixed flag |
| cfg_q | output | CFG_W | Control register contents |

## Verification
The bench builds the block with its default parameters: 16-bit slots, frame lengths of 256 and 512, and a split after four devices. It sweeps the cascade count over all eight values, so both frame lengths and the switch between them are measured arithmetically. A second instance in slave mode is chained on the delayed frame sync. This exposes the slot offset and the synchroniser latency. Several data patterns, a secondary request and power-down with a programmed register cover the framing and retention cases.

// File: rtl/codec_sport_frame.sv
module codec_sport_frame #(
  parameter int SLOT_BITS    = 16,
  parameter int SHORT_LEN    = 256,
  parameter int LONG_LEN     = 512,
  parameter int CASC_W       = 4,
  parameter int CASC_SPLIT   = 4,
  parameter int CFG_W        = 8,
  parameter int FLAG_SEL_BIT = 4,
  parameter int FLAG_VAL_BIT = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwrdn_n,
  input  logic                 master_sel,
  input  logic [CASC_W-1:0]    casc_cnt,
  input  logic                 sec_req,
  input  logic                 sclk_i,
  input  logic                 fs_i,
  input  logic                 din,
  input  logic [SLOT_BITS-1:0] tx_word,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic                 sclk_o,
  output logic                 fs_o,
  output logic                 fsd_o,
  output logic                 dout,
  output logic [SLOT_BITS-1:0] rx_word,
  output logic                 rx_valid,
  output logic                 flag_o,
  output logic [CFG_W-1:0]     cfg_q
);
  localparam int PW = $clog2(LONG_LEN);
  localparam int SW = $clog2(SLOT_BITS);
  localparam int DW = SW + 1;
  localparam logic [PW-1:0] SLOT_P = PW'(SLOT_BITS);
  localparam logic [PW-1:0] LAST_S = PW'(SHORT_LEN - 1);
  localparam logic [PW-1:0] LAST_L = PW'(LONG_LEN - 1);
  localparam logic [SW-1:0] BIT_END = SW'(SLOT_BITS - 1);
  localparam logic [DW-1:0] DLY_ON  = DW'(SLOT_BITS - 1);
  localparam logic [DW-1:0] DLY_OFF = DW'(2 * SLOT_BITS - 1);

  logic sclk_q, s1, s2, f1;
  logic fs_prev, fsd_q, active, drun;
  logic sec_cur, sec_pend, sec_sched, synced;
  logic [PW-1:0] pcnt;
  logic [SW-1:0] fcnt;
  logic [DW-1:0] dcnt;
  logic [SLOT_BITS-1:0] tsh;
  logic [SLOT_BITS-2:0] rsh;

  wire [PW-1:0] frame_last = (casc_cnt > CASC_W'(CASC_SPLIT)) ? LAST_L : LAST_S;
  wire [PW-1:0] half       = (frame_last >> 1) + PW'(1);
  wire [PW-1:0] pn         = (pcnt >= frame_last) ? '0 : pcnt + PW'(1);

  wire ev_rise   = pwrdn_n & (master_sel ? ~sclk_q : (s1 & ~s2));
  wire ev_fall   = pwrdn_n & (master_sel ?  sclk_q : (~s1 & s2));
  wire m_low     = (pn < SLOT_P) | (sec_sched & (pn >= half) & (pn < half + SLOT_P));
  wire fs_now    = master_sel ? ~m_low : f1;
  wire start     = ev_rise & fs_prev & ~fs_now;
  wire sec_start = master_sel ? (pn >= half) : (sec_pend & synced);

  assign sclk_o = sclk_q;
  assign fs_o   = master_sel ? fs_prev : 1'b1;
  assign fsd_o  = fsd_q;
  assign dout   = active & tsh[SLOT_BITS-1];
  assign flag_o = cfg_q[FLAG_SEL_BIT] ? cfg_q[FLAG_VAL_BIT] : sec_cur;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwrdn_n || !master_sel) sclk_q <= 1'b0;
    else                                   sclk_q <= ~sclk_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      f1 <= 1'b1;
    end else begin
      s1 <= sclk_i;
      s2 <= s1;
      f1 <= fs_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_we)   cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwrdn_n) begin
      pcnt      <= '1;
      fs_prev   <= 1'b1;
      fsd_q     <= 1'b1;
      active    <= 1'b0;
      drun      <= 1'b0;
      fcnt      <= '0;
      dcnt      <= '0;
      tsh       <= '0;
      rsh       <= '0;
      sec_cur   <= 1'b0;
      sec_pend  <= 1'b0;
      sec_sched <= 1'b0;
      synced    <= 1'b0;
      rx_valid  <= 1'b0;
      if (!rst_n) rx_word <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (ev_rise) begin
        fs_prev <= fs_now;
        pcnt    <= pn;
        if (master_sel && pn == SLOT_P) sec_sched <= sec_pend;
        if (master_sel && pn == '0)     sec_sched <= 1'b0;
        if (start) begin
          active  <= 1'b1;
          tsh     <= tx_word;
          fcnt    <= '0;
          dcnt    <= '0;
          drun    <= 1'b1;
          sec_cur <= sec_start;
          if (!sec_start) synced <= 1'b1;
        end else begin
          if (active) tsh <= tsh << 1;
          if (drun) begin
            dcnt <= dcnt + DW'(1);
            if (dcnt == DLY_ON) fsd_q <= 1'b0;
            if (dcnt == DLY_OFF) begin
              fsd_q <= 1'b1;
              drun  <= 1'b0;
            end
          end
        end
      end
      if (ev_fall && active) begin
        rsh  <= {rsh[SLOT_BITS-3:0], din};
        fcnt <= fcnt + SW'(1);
        if (fcnt == BIT_END) begin
          active   <= 1'b0;
          rx_valid <= 1'b1;
          rx_word  <= {rsh, din};
          if (sec_cur) sec_pend <= 1'b0;
        end
      end
      if (sec_req) sec_pend <= 1'b1;
    end
  end

  // R7
  pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (!sclk_o && fs_o && fsd_o && !dout));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));

  // R2
  fs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $stable(master_sel) && $fell(fs_o)) |-> sclk_o);

  // R3
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && rx_valid) |-> !fs_o);

  // R4
  fsd_after_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $fell(fsd_o)) |-> fs_o);

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $rose(flag_o) && !cfg_q[FLAG_SEL_BIT] && $stable(cfg_q)) |-> !fs_o);

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && $past(!master_sel)) |-> (!sclk_o && fs_o));
endmodule

// File: tb/codec_sport_frame_bench.sv
module codec_sport_frame_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrdn_n = 1'b1;
  logic [3:0] casc = 4'd1;
  logic sec_req = 1'b0;
  logic din = 1'b0;
  logic [15:0] tx_word = 16'h0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h0;

  logic sclk_o, fs_o, fsd_o, dout, rx_valid, flag_o;
  logic [15:0] rx_word;
  logic [7:0] cfg_q;
  logic s_sclk_o, s_fs_o, s_fsd_o, s_dout, s_rx_valid, s_flag;
  logic [15:0] s_rx_word;
  logic [7:0] s_cfg;

  int cyc = 0, checks = 0, errors = 0, sr_cnt = 0, rv_cnt = 0;
  logic sclk_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (sclk_o && !sclk_prev) sr_cnt = sr_cnt + 1;
    sclk_prev = sclk_o;
    if (rx_valid) rv_cnt = rv_cnt + 1;
  end

  codec_sport_frame u_codec_sport_frame (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .master_sel(1'b1), .casc_cnt(casc),
    .sec_req(sec_req), .sclk_i(1'b0), .fs_i(1'b1), .din(din), .tx_word(tx_word),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sclk_o(sclk_o), .fs_o(fs_o), .fsd_o(fsd_o),
    .dout(dout), .rx_word(rx_word), .rx_valid(rx_valid), .flag_o(flag_o), .cfg_q(cfg_q));

  codec_sport_frame u_codec_sport_frame_slv (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(1'b1), .master_sel(1'b0), .casc_cnt(casc),
    .sec_req(1'b0), .sclk_i(sclk_o), .fs_i(fsd_o), .din(1'b0), .tx_word(16'h1234),
    .cfg_we(1'b0), .cfg_wdata(8'h0), .sclk_o(s_sclk_o), .fs_o(s_fs_o), .fsd_o(s_fsd_o),
    .dout(s_dout), .rx_word(s_rx_word), .rx_valid(s_rx_valid), .flag_o(s_flag), .cfg_q(s_cfg));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_fall(output int t);
    logic p;
    p = fs_o;
    forever begin
      @(negedge clk);
      if (p && !fs_o) break;
      p = fs_o;
    end
    #1;
    t = cyc;
  endtask

  task automatic wait_lvl(input bit slv, input logic lvl, output int t);
    forever begin
      @(negedge clk);
      if ((slv ? s_fsd_o : fsd_o) == lvl) break;
    end
    t = cyc;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] tx, input logic [15:0] pat);
    int t0, r0;
    logic [15:0] got;
    tx_word = tx;
    wait_fall(t0);
    chk("R2 fs falls with sclk high", sclk_o, 1);
    r0 = rv_cnt;
    for (int k = 0; k < 16; k++) begin
      got[15-k] = dout;
      din = pat[15-k];
      if (k == 15) chk("R2 fs low through bit 16", fs_o, 0);
      @(negedge clk);
      @(negedge clk);
    end
    #1;
    din = 1'b0;
    chk("R3 dout word MSB first", got, tx);
    chk("R3 rx_word", rx_word, pat);
    chk("R3 rx_valid single pulse", rv_cnt - r0, 1);
    chk("R2 fs high after 16 periods", fs_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all R) actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, r0, r1, tf, tr, tsf, tsr, ts, tn, tq;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 cfg reset", cfg_q, 0);
    chk("R9 fs reset", fs_o, 1);
    chk("R9 fsd reset", fsd_o, 1);
    chk("R9 sclk reset", sclk_o, 0);
    chk("R9 flag reset", flag_o, 0);
    rst_n = 1'b1;

    // R2 R3 data patterns
    xfer(16'hA5C3, 16'h3C5A);
    xfer(16'h8000, 16'h0001);
    xfer(16'hFFFF, 16'h0000);
    xfer(16'h0001, 16'hFFFF);

    // R1 ratio sweep
    for (int c = 1; c <= 8; c++) begin
      casc = 4'(c);
      wait_fall(t0);
      wait_fall(t0);
      r0 = sr_cnt;
      wait_fall(t1);
      r1 = sr_cnt;
      chk($sformatf("R1 period casc %0d", c), t1 - t0, (c <= 4) ? 512 : 1024);
      chk($sformatf("R1 sclk rises casc %0d", c), r1 - r0, (c <= 4) ? 256 : 512);
    end
    casc = 4'd1;
    wait_fall(t0);

    // R4 delayed frame sync, master and chained slave
    wait_fall(t0);
    wait_lvl(1'b0, 1'b0, tf);
    wait_lvl(1'b0, 1'b1, tr);
    wait_lvl(1'b1, 1'b0, tsf);
    wait_lvl(1'b1, 1'b1, tsr);
    chk("R4 fsd offset", tf - t0, 32);
    chk("R4 fsd low length", tr - tf, 32);
    chk("R4 slave fsd offset", tsf - tf, 34);
    chk("R4 slave fsd low length", tsr - tsf, 32);
    // R10 slave outputs
    chk("R10 slave sclk_o low", s_sclk_o, 0);
    chk("R10 slave fs_o high", s_fs_o, 1);

    // R5 secondary frame
    wait_fall(t0);
    chk("R6 flag low in primary", flag_o, 0);
    @(negedge clk);
    sec_req = 1'b1;
    @(negedge clk);
    sec_req = 1'b0;
    wait_fall(ts);
    chk("R5 secondary placed midway", ts - t0, 256);
    chk("R6 flag high in secondary", flag_o, 1);
    wait_fall(tn);
    chk("R5 next primary", tn - ts, 256);
    chk("R6 flag low in next primary", flag_o, 0);
    wait_fall(tq);
    chk("R5 request cleared", tq - tn, 512);

    // R6 fixed flag value
    cfg_write(8'h18);
    #1;
    chk("R6 flag forced 1", flag_o, 1);
    cfg_write(8'h10);
    #1;
    chk("R6 flag forced 0", flag_o, 0);
    // R8 write enable required
    @(negedge clk);
    cfg_wdata = 8'hE7;
    @(negedge clk);
    chk("R8 no write without enable", cfg_q, 8'h10);
    cfg_write(8'h18);

    // R7 R8 power-down
    @(negedge clk);
    pwrdn_n = 1'b0;
    @(negedge clk);
    #1;
    r0 = sr_cnt;
    repeat (20) @(negedge clk);
    #1;
    chk("R7 sclk stopped", sr_cnt - r0, 0);
    chk("R7 sclk low", sclk_o, 0);
    chk("R7 fs high", fs_o, 1);
    chk("R7 fsd high", fsd_o, 1);
    chk("R7 dout low", dout, 0);
    chk("R8 cfg kept in power-down", cfg_q, 8'h18);
    pwrdn_n = 1'b1;
    @(negedge clk);
    chk("R7 frame on first clock after release", fs_o, 0);
    chk("R8 cfg kept after release", cfg_q, 8'h18);
    chk("R6 flag after release", flag_o, 1);

    // R9 reset again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 cfg cleared", cfg_q, 0);
    chk("R9 flag cleared", flag_o, 0);
    chk("R9 fs high", fs_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule